// File: doc/BRIEF.md
# Program Counter Action Unit

This block is the program counter of a processor whose every instruction has the same layout: the top four bits of each instruction word tell the counter what to do in that cycle, while other fields steer other registers. The counter holds a 16-bit address and, according to the action code, either keeps it, steps it past a fetched word, places it on the address adder, places its value plus two on the internal data bus, or takes a new value from that bus.

Branches are relative and always take their offset from memory. The counter puts its own value on the address adder so that the word right after the instruction is read. A taken branch adds that word to the counter as a signed offset. A branch that is not taken steps over the offset word. Subroutine entry and exit each take two instructions, because only one memory access is allowed per instruction. The store action writes the counter plus two while the stack pointer pushes. A following branch then jumps. On return, the load action takes the popped word from the data bus.

The top module has no memory, no other registers and no logic for a bus owner. Its address contribution is zero when it is not requesting, and its data drive is zero when it is not writing, so that the surrounding logic can OR or add the contributions together.

Top module: `pc_action_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the counter reads 0x0000. With code 0000 applied, no address request and no data drive are raised.
- R2: Code 0000 (no operation) and the unassigned codes 0101 and 0111 leave the counter unchanged. They raise neither the address request nor the data drive, whatever the flags or the data input hold.
- R3: Code 0001 (fetch) puts the counter on the address output and raises the address request. At the clock edge the counter then advances by one, wrapping from 0xFFFF to 0x0000.
- R4: Code 0011 (project) puts the counter on the address output and raises the address request. The counter keeps its value.
- R5: Code 0010 (unconditional branch) puts the counter on the address output and raises the address request. At the edge the counter becomes itself plus the data input, with the data input read as a signed 16-bit offset and the sum taken modulo 2^16.
- R6: Codes 1000 to 1111 are conditional branches that test flag bit n, where n is the code's low three bits. Code 1001 tests bit 1, the accumulator-zero flag. Each of these codes puts the counter on the address output and raises the address request. If the tested bit is 1, the counter becomes counter plus data input (signed, modulo 2^16). If the bit is 0, the counter becomes counter plus one.
- R7: Code 0110 (store return) drives counter plus two (modulo 2^16) on the data output and raises the data drive. It raises no address request, and the counter keeps its value.
- R8: Code 0100 (load) loads the counter from the data input at the edge. It raises neither the address request nor the data drive.
- R9: The address output is 0x0000 whenever the address request is low. The data output is 0x0000 whenever the data drive is low. The address request and the data drive are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act | input | 4 | Action code from instruction bits 15..12 |
| flags | input | 8 | Condition flags; bit 1 is accumulator zero |
| data_in | input | 16 | Word read from the internal data bus |
| pc | output | 16 | Current counter value |
| addr_out | output | 16 | Contribution to the address adder |
| addr_req | output | 1 | Valid-address request |
| data_out | output | 16 | Value driven onto the data bus |
| data_drv | output | 1 | Data drive enable (write cycle) |

## Verification
The properties assume that the action code, the flags and the data input are stable and known around each rising edge. They also assume that the data input already carries the memory word when a branch samples it. The stimulus changes every input only on the falling edge, and it sets the data input together with the action code. As a result, each branch or load sees its offset or target word for the whole cycle. Flags and data are also driven to non-zero values during actions that must ignore them, so that the checks of the unchanged counter are meaningful.

// File: rtl/pc_action_unit.sv
module pc_action_unit #(
  parameter int W      = 16,
  parameter int NFLAG  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       act,
  input  logic [NFLAG-1:0] flags,
  input  logic [W-1:0]     data_in,
  output logic [W-1:0]     pc,
  output logic [W-1:0]     addr_out,
  output logic             addr_req,
  output logic [W-1:0]     data_out,
  output logic             data_drv
);
  localparam int FSEL = $clog2(NFLAG);

  localparam logic [3:0] ACT_NOP   = 4'b0000;
  localparam logic [3:0] ACT_FETCH = 4'b0001;
  localparam logic [3:0] ACT_BRA   = 4'b0010;
  localparam logic [3:0] ACT_PROJ  = 4'b0011;
  localparam logic [3:0] ACT_LOAD  = 4'b0100;
  localparam logic [3:0] ACT_STR2  = 4'b0110;

  logic [W-1:0] pc_q, pc_d;
  logic         cond_hit;

  assign cond_hit = flags[act[FSEL-1:0]];

  always_comb begin
    pc_d     = pc_q;
    addr_req = 1'b0;
    data_drv = 1'b0;
    if (act[3]) begin
      addr_req = 1'b1;
      pc_d     = cond_hit ? pc_q + data_in : pc_q + W'(1);
    end else begin
      case (act)
        ACT_FETCH: begin addr_req = 1'b1; pc_d = pc_q + W'(1); end
        ACT_BRA:   begin addr_req = 1'b1; pc_d = pc_q + data_in; end
        ACT_PROJ:  addr_req = 1'b1;
        ACT_LOAD:  pc_d = data_in;
        ACT_STR2:  data_drv = 1'b1;
        ACT_NOP:   pc_d = pc_q;
        default:   pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign addr_out = addr_req ? pc_q : '0;
  assign data_out = data_drv ? pc_q + W'(2) : '0;
endmodule

module pc_action_unit_chk #(
  parameter int W     = 16,
  parameter int NFLAG = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       act,
  input logic [NFLAG-1:0] flags,
  input logic [W-1:0]     data_in,
  input logic [W-1:0]     pc,
  input logic [W-1:0]     addr_out,
  input logic             addr_req,
  input logic [W-1:0]     data_out,
  input logic             data_drv
);
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> pc == '0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 4'b0000 || act == 4'b0101 || act == 4'b0111)
      |-> (!addr_req && !data_drv) ##1 pc == $past(pc));

  a_r3_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    act == 4'b0001 |=> pc == $past(pc) + W'(1));

  a_r4_project: assert property (@(posedge clk) disable iff (!rst_n)
    act == 4'b0011 |-> addr_req && addr_out == pc ##1 $stable(pc));

  a_r5_branch: assert property (@(posedge clk) disable iff (!rst_n)
    act == 4'b0010 |=> pc == $past(pc) + $past(data_in));

  a_r6_cond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    act[3] && flags[act[2:0]] |=> pc == $past(pc) + $past(data_in));

  a_r6_cond_skip: assert property (@(posedge clk) disable iff (!rst_n)
    act[3] && !flags[act[2:0]] |=> pc == $past(pc) + W'(1));

  a_r7_store: assert property (@(posedge clk) disable iff (!rst_n)
    act == 4'b0110 |-> data_drv && !addr_req && data_out == pc + W'(2));

  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    act == 4'b0100 |=> pc == $past(data_in));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_req && data_drv));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_req |-> addr_out == '0) and (!data_drv |-> data_out == '0));
endmodule

bind pc_action_unit pc_action_unit_chk #(.W(W), .NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .act(act), .flags(flags), .data_in(data_in),
  .pc(pc), .addr_out(addr_out), .addr_req(addr_req),
  .data_out(data_out), .data_drv(data_drv)
);

// File: tb/pc_action_unit_tb.sv
module pc_action_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  act = 4'b0000;
  logic [7:0]  flags = 8'h00;
  logic [15:0] data_in = 16'h0000;
  logic [15:0] pc, addr_out, data_out;
  logic        addr_req, data_drv;

  pc_action_unit u_dut (
    .clk(clk), .rst_n(rst_n), .act(act), .flags(flags), .data_in(data_in),
    .pc(pc), .addr_out(addr_out), .addr_req(addr_req),
    .data_out(data_out), .data_drv(data_drv)
  );

  always #5 clk = ~clk;

  typedef struct {
    string       tag;
    logic        req;
    logic [15:0] addr;
    logic        drv;
    logic [15:0] dout;
    logic [15:0] pc_after;
  } exp_t;

  exp_t        q[$];
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [15:0] mpc = 16'h0000;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] a, logic [7:0] f, logic [15:0] d);
    exp_t e;
    @(negedge clk);
    act = a; flags = f; data_in = d;
    e.tag = tag; e.req = 1'b0; e.addr = 16'h0; e.drv = 1'b0; e.dout = 16'h0;
    e.pc_after = mpc;
    if (a[3]) begin
      e.req = 1'b1; e.addr = mpc;
      e.pc_after = f[a[2:0]] ? mpc + d : mpc + 16'd1;
    end else begin
      case (a)
        4'b0001: begin e.req = 1'b1; e.addr = mpc; e.pc_after = mpc + 16'd1; end
        4'b0010: begin e.req = 1'b1; e.addr = mpc; e.pc_after = mpc + d; end
        4'b0011: begin e.req = 1'b1; e.addr = mpc; end
        4'b0100: e.pc_after = d;
        4'b0110: begin e.drv = 1'b1; e.dout = mpc + 16'd2; end
        default: ;
      endcase
    end
    mpc = e.pc_after;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " outputs"}, {addr_req, addr_out, data_drv, data_out},
              {e.req, e.addr, e.drv, e.dout});
        @(posedge clk);
        #1;
        check({e.tag, " pc"}, 64'(pc), 64'(e.pc_after));
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1 pc in reset", 64'(pc), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 pc after release", 64'(pc), 64'h0);
    check("R9 idle outputs", {addr_req, addr_out, data_drv, data_out}, 64'h0);

    step("R3 fetch", 4'b0001, 8'hFF, 16'h1234);
    step("R3 fetch", 4'b0001, 8'h00, 16'h0000);
    step("R3 fetch", 4'b0001, 8'h00, 16'hBEEF);
    step("R2 nop", 4'b0000, 8'hFF, 16'h5555);
    step("R2 unassigned 0101", 4'b0101, 8'hFF, 16'hAAAA);
    step("R2 unassigned 0111", 4'b0111, 8'hFF, 16'h7777);
    step("R4 project", 4'b0011, 8'hFF, 16'h4321);
    step("R5 branch fwd", 4'b0010, 8'h00, 16'h0006);
    step("R5 branch back", 4'b0010, 8'hFF, 16'hFFF9);
    step("R7 store", 4'b0110, 8'hFF, 16'h9999);
    step("R6 az taken", 4'b1001, 8'h02, 16'h0010);
    step("R6 az skip", 4'b1001, 8'hFD, 16'h0010);
    step("R6 bit0 taken", 4'b1000, 8'h01, 16'hFFFE);
    step("R6 bit7 skip", 4'b1111, 8'h7F, 16'h0100);
    step("R6 bit7 taken", 4'b1111, 8'h80, 16'h0100);
    step("R8 load", 4'b0100, 8'hFF, 16'hFFFF);
    step("R7 store wrap", 4'b0110, 8'h00, 16'h0000);
    step("R3 fetch wrap", 4'b0001, 8'h00, 16'h0000);
    step("R8 load high", 4'b0100, 8'h00, 16'hFFF0);
    step("R5 branch wrap", 4'b0010, 8'h00, 16'h0020);
    step("R2 nop after", 4'b0000, 8'h00, 16'hFFFF);

    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule